// File: doc/BRIEF.md
# Serial NAND Feature Register Slave

This block is the device-side register front end of a serial NAND flash. It decodes SPI frames (mode 0, most significant bit first) that arrive on four oversampled pins. It serves the two feature-register commands: one reads a register and the other writes it. Four 8-bit registers can be addressed: lock control, option enables, status and output drive. The block also holds the write-enable latch. It runs a programmable busy interval for the device reset, program, page-read and block-erase commands, and it folds the array's result into the status word when the interval ends.

The surrounding device drives `busy_len` with the length of the busy interval in clock cycles. It presents `res_fail` and `res_ecc`, which the block samples in the last busy cycle. A host reads the status register in a loop until the operation-in-progress bit drops. It then inspects the fail and ECC fields.

Top module: `nand_feat_slave`

## Requirements
- R1: SPI mode 0 framing, MSB first. The block samples MOSI on a rising SCK and updates MISO after a falling SCK. A frame is one low period of `spi_cs_n`. Deasserting chip select part-way through a byte discards that byte, and a register write whose data byte is incomplete has no effect.
- R2: Opcode 0x0F followed by an address byte returns the addressed register MSB first during the third byte. The value is taken when the address byte completes.
- R3: Opcode 0x1F followed by an address byte and a data byte writes the register when the data byte completes. Register addresses: 0xA0 lock, 0xB0 options, 0xC0 status, 0xD0 drive. Writable bits: lock mask 0xBE, options mask 0xD1 (bit4 = ECC enable), drive mask 0x60. Other bits read 0.
- R4: Any other address is rejected. A write to it changes nothing and a read of it returns 0x00.
- R5: After synchronous reset: lock = 0x1C, options = 0x00, drive = 0x00, status = 0x00 (write latch clear, not busy).
- R6: Status layout: bit0 busy, bit1 write latch, bit2 erase fail, bit3 program fail, bits 6:4 ECC code, bit7 = 0. The status register ignores writes. A read taken during a busy interval returns bit0 = 1.
- R7: Opcode 0x06 sets the write latch at the end of the frame and opcode 0x04 clears it.
- R8: Opcode 0xFF starts a busy interval of max(`busy_len`,1) cycles. It is accepted even while the block is busy, and it then restarts the interval.
- R9: Program (0x10) and erase (0xD8) start a busy interval only when the write latch is set. Otherwise they are ignored.
- R10: When a program or erase completes, the write latch clears. The program-fail bit (program) or the erase-fail bit (erase) takes `res_fail` from the last busy cycle, and the other fail bit is kept.
- R11: Page read (0x13) starts a busy interval whatever the latch holds and leaves the latch unchanged. When it completes, the ECC code takes `res_ecc` if options bit4 is set, and 000 otherwise.
- R12: While busy, only the register read and the reset opcode have an effect. Register writes, latch set/clear, program, read and erase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out, 0 when not selected |
| busy_len | input | CNT_W (16) | Busy interval length in clock cycles |
| res_fail | input | 1 | Array operation failed, sampled at completion |
| res_ecc | input | 3 | Array ECC result code, sampled at completion |

## Verification
The assertions check on every cycle that the reset opcode starts a busy interval. They also check that a program without the write latch never starts one, that the latch drops when a program or erase finishes, and that the ECC field stays zero when ECC is disabled. Further cycle checks cover that no register write issues while busy, that a status snapshot taken while busy shows bit0, and that bytes complete only on the eighth sampled bit. Only the bench scenarios can show the results seen over the wire. These include the masked read-back values and the rejected addresses, the interval restart on a second reset, the fail bits that persist across operations, and a write aborted mid-byte.

// File: rtl/nand_feat_pkg.sv
package nand_feat_pkg;

    // Command opcodes
    localparam logic [7:0] OP_GET    = 8'h0F;
    localparam logic [7:0] OP_SET    = 8'h1F;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RESET  = 8'hFF;
    localparam logic [7:0] OP_PEXEC  = 8'h10;
    localparam logic [7:0] OP_PREAD  = 8'h13;
    localparam logic [7:0] OP_BERASE = 8'hD8;

    // Register addresses
    localparam logic [7:0] ADDR_LOCK = 8'hA0;
    localparam logic [7:0] ADDR_OPT  = 8'hB0;
    localparam logic [7:0] ADDR_STAT = 8'hC0;
    localparam logic [7:0] ADDR_DRV  = 8'hD0;

    // Writable bit masks and power-up values
    localparam logic [7:0] LOCK_MASK = 8'hBE;
    localparam logic [7:0] OPT_MASK  = 8'hD1;
    localparam logic [7:0] DRV_MASK  = 8'h60;
    localparam logic [7:0] LOCK_INIT = 8'h1C;
    localparam int         OPT_ECC_BIT = 4;

    // Byte position within a frame, saturating
    localparam int BIDX_W = 2;

    typedef enum logic [1:0] {
        SEL_LOCK = 2'd0,
        SEL_OPT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DRV  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KIND_RESET = 2'd0,
        KIND_PROG  = 2'd1,
        KIND_READ  = 2'd2,
        KIND_ERASE = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } reg_addr_t;

    // One pulse per accepted frame-level command
    typedef struct packed {
        logic wren;
        logic wrdi;
        logic rst;
        logic prog;
        logic read;
        logic erase;
    } cmd_t;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] ecc;
        logic       pfail;
        logic       efail;
        logic       wel;
        logic       oip;
    } status_t;

    function automatic reg_addr_t decode_addr(input logic [7:0] a);
        reg_addr_t r;
        r.valid = 1'b1;
        r.sel   = SEL_LOCK;
        case (a)
            ADDR_LOCK: r.sel = SEL_LOCK;
            ADDR_OPT:  r.sel = SEL_OPT;
            ADDR_STAT: r.sel = SEL_STAT;
            ADDR_DRV:  r.sel = SEL_DRV;
            default:   r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] write_mask(input reg_sel_e s);
        case (s)
            SEL_LOCK: return LOCK_MASK;
            SEL_OPT:  return OPT_MASK;
            SEL_DRV:  return DRV_MASK;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_feat_spi.sv
module nand_feat_spi
    import nand_feat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              tx_load,
    input  logic [7:0]        tx_byte,
    output logic              spi_miso,
    output logic              byte_done,
    output logic [7:0]        rx_byte,
    output logic [BIDX_W-1:0] byte_idx,
    output logic              frame_end
);

    logic [SYNC_STAGES-1:0] cs_sync, sck_sync, mosi_sync;
    logic                   sck_prev, cs_act_prev;
    logic                   cs_act, sck_s, mosi_s, sck_rise, sck_fall;
    logic [2:0]             bit_cnt;
    logic [7:0]             sh_in, tx_sh, tx_pend;
    logic                   tx_pend_v;
    logic [BIDX_W-1:0]      idx_q;

    // Input synchronizer chains
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sync   <= '1;
            sck_sync  <= '0;
            mosi_sync <= '0;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                cs_sync[i]   <= cs_sync[i-1];
                sck_sync[i]  <= sck_sync[i-1];
                mosi_sync[i] <= mosi_sync[i-1];
            end
            cs_sync[0]   <= spi_cs_n;
            sck_sync[0]  <= spi_sck;
            mosi_sync[0] <= spi_mosi;
        end
    end

    assign cs_act   = ~cs_sync[SYNC_STAGES-1];
    assign sck_s    = sck_sync[SYNC_STAGES-1];
    assign mosi_s   = mosi_sync[SYNC_STAGES-1];
    assign sck_rise = cs_act & sck_s & ~sck_prev;
    assign sck_fall = cs_act & ~sck_s & sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev    <= 1'b0;
            cs_act_prev <= 1'b0;
            frame_end   <= 1'b0;
            byte_done   <= 1'b0;
            rx_byte     <= '0;
            byte_idx    <= '0;
            idx_q       <= '0;
            bit_cnt     <= '0;
            sh_in       <= '0;
            tx_sh       <= '0;
            tx_pend     <= '0;
            tx_pend_v   <= 1'b0;
        end else begin
            sck_prev    <= sck_s;
            cs_act_prev <= cs_act;
            frame_end   <= cs_act_prev & ~cs_act;
            byte_done   <= 1'b0;
            if (!cs_act) begin
                bit_cnt   <= '0;
                idx_q     <= '0;
                tx_sh     <= '0;
                tx_pend_v <= 1'b0;
            end else begin
                if (sck_rise) begin
                    sh_in   <= {sh_in[6:0], mosi_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {sh_in[6:0], mosi_s};
                        byte_idx  <= idx_q;
                        if (idx_q != {BIDX_W{1'b1}}) begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                if (sck_fall) begin
                    if (tx_pend_v) begin
                        tx_sh     <= tx_pend;
                        tx_pend_v <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
                if (tx_load) begin
                    tx_pend   <= tx_byte;
                    tx_pend_v <= 1'b1;
                end
            end
        end
    end

    assign spi_miso = cs_act & tx_sh[7];

    // R1: a byte completes only on the eighth sampled bit
    a_r1_byte_on_eighth: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> ($past(bit_cnt) == 3'd7));

    // R1: no byte completes once chip select is seen released
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !byte_done);

endmodule

// File: rtl/nand_feat_dec.sv
module nand_feat_dec
    import nand_feat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [BIDX_W-1:0] byte_idx,
    input  logic              frame_end,
    input  logic              busy,
    input  logic [3:0][7:0]   rd_regs,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic              wr_en,
    output reg_sel_e          wr_sel,
    output logic [7:0]        wr_data,
    output cmd_t              cmd
);

    logic [7:0] opc;
    reg_addr_t  addr_q;
    reg_addr_t  addr_now;

    assign addr_now = decode_addr(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            opc     <= '0;
            addr_q  <= '0;
            tx_load <= 1'b0;
            tx_byte <= '0;
            wr_en   <= 1'b0;
            wr_sel  <= SEL_LOCK;
            wr_data <= '0;
            cmd     <= '0;
        end else begin
            tx_load <= 1'b0;
            wr_en   <= 1'b0;
            cmd     <= '0;
            if (byte_done) begin
                case (byte_idx)
                    2'd0: opc <= rx_byte;
                    2'd1: begin
                        if (opc == OP_GET || opc == OP_SET) begin
                            addr_q <= addr_now;
                        end
                        if (opc == OP_GET) begin
                            tx_load <= 1'b1;
                            tx_byte <= addr_now.valid ? rd_regs[addr_now.sel] : 8'h00;
                        end
                    end
                    2'd2: begin
                        if (opc == OP_SET && addr_q.valid && !busy) begin
                            wr_en   <= 1'b1;
                            wr_sel  <= addr_q.sel;
                            wr_data <= rx_byte;
                        end
                    end
                    default: ;
                endcase
            end
            if (frame_end) begin
                cmd.rst   <= (opc == OP_RESET);
                cmd.wren  <= (opc == OP_WREN)   && !busy;
                cmd.wrdi  <= (opc == OP_WRDI)   && !busy;
                cmd.prog  <= (opc == OP_PEXEC)  && !busy;
                cmd.read  <= (opc == OP_PREAD)  && !busy;
                cmd.erase <= (opc == OP_BERASE) && !busy;
                opc       <= '0;
                addr_q    <= '0;
            end
        end
    end

    // R12: a data byte arriving while busy never issues a register write
    a_r12_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        (byte_done && busy) |=> !wr_en);

    // R6: a status snapshot taken while busy carries the busy bit
    a_r6_oip_readback: assert property (@(posedge clk) disable iff (rst)
        (byte_done && byte_idx == 2'd1 && opc == OP_GET &&
         rx_byte == ADDR_STAT && busy) |=> tx_byte[0]);

    // R8: at most one frame-level command per cycle
    a_r8_single_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

endmodule

// File: rtl/nand_feat_regs.sv
module nand_feat_regs
    import nand_feat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] busy_len,
    input  logic             res_fail,
    input  logic [2:0]       res_ecc,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [7:0]       wr_data,
    input  cmd_t             cmd,
    output logic [3:0][7:0]  rd_regs,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [7:0]       lock_q, opt_q, drv_q;
    logic             wel, efail, pfail;
    logic [2:0]       ecc_q;
    logic [CNT_W-1:0] cnt;
    op_kind_e         kind;
    logic [CNT_W-1:0] load_val;
    logic             last_cyc;
    status_t          stat;

    assign load_val = (busy_len == '0) ? ONE : busy_len;
    assign busy     = (cnt != '0);
    assign last_cyc = (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= LOCK_INIT;
            opt_q  <= '0;
            drv_q  <= '0;
            wel    <= 1'b0;
            efail  <= 1'b0;
            pfail  <= 1'b0;
            ecc_q  <= '0;
            cnt    <= '0;
            kind   <= KIND_RESET;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    SEL_LOCK: lock_q <= wr_data & write_mask(SEL_LOCK);
                    SEL_OPT:  opt_q  <= wr_data & write_mask(SEL_OPT);
                    SEL_DRV:  drv_q  <= wr_data & write_mask(SEL_DRV);
                    default: ;
                endcase
            end
            if (cmd.wren) wel <= 1'b1;
            if (cmd.wrdi) wel <= 1'b0;

            if (cmd.rst) begin
                cnt  <= load_val;
                kind <= KIND_RESET;
            end else if (cmd.prog && wel) begin
                cnt  <= load_val;
                kind <= KIND_PROG;
            end else if (cmd.erase && wel) begin
                cnt  <= load_val;
                kind <= KIND_ERASE;
            end else if (cmd.read) begin
                cnt  <= load_val;
                kind <= KIND_READ;
            end else if (busy) begin
                cnt <= cnt - ONE;
                if (last_cyc) begin
                    case (kind)
                        KIND_PROG: begin
                            pfail <= res_fail;
                            wel   <= 1'b0;
                        end
                        KIND_ERASE: begin
                            efail <= res_fail;
                            wel   <= 1'b0;
                        end
                        KIND_READ:
                            ecc_q <= opt_q[OPT_ECC_BIT] ? res_ecc : 3'b000;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        stat.rsvd  = 1'b0;
        stat.ecc   = ecc_q;
        stat.pfail = pfail;
        stat.efail = efail;
        stat.wel   = wel;
        stat.oip   = busy;
        rd_regs[SEL_LOCK] = lock_q;
        rd_regs[SEL_OPT]  = opt_q;
        rd_regs[SEL_STAT] = stat;
        rd_regs[SEL_DRV]  = drv_q;
    end

    // R8: the reset opcode always opens a busy interval
    a_r8_reset_busy: assert property (@(posedge clk) disable iff (rst)
        cmd.rst |=> busy);

    // R9: a program without the write latch leaves the block idle
    a_r9_no_start: assert property (@(posedge clk) disable iff (rst)
        (cmd.prog && !wel && !busy) |=> !busy);

    // R10: the latch drops when a program or erase finishes
    a_r10_wel_drop: assert property (@(posedge clk) disable iff (rst)
        (last_cyc && !cmd.rst && (kind == KIND_PROG || kind == KIND_ERASE)) |=> !wel);

    // R11: with ECC disabled a finished read leaves a zero ECC code
    a_r11_ecc_gated: assert property (@(posedge clk) disable iff (rst)
        (last_cyc && !cmd.rst && kind == KIND_READ && !opt_q[OPT_ECC_BIT]) |=> (ecc_q == 3'b000));

endmodule

// File: rtl/nand_feat_slave.sv
module nand_feat_slave
    import nand_feat_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [CNT_W-1:0] busy_len,
    input  logic             res_fail,
    input  logic [2:0]       res_ecc
);

    logic              tx_load, byte_done, frame_end, wr_en, busy;
    logic [7:0]        tx_byte, rx_byte, wr_data;
    logic [BIDX_W-1:0] byte_idx;
    reg_sel_e          wr_sel;
    cmd_t              cmd;
    logic [3:0][7:0]   rd_regs;

    nand_feat_spi #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
        .clk(clk), .rst(rst),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .tx_load(tx_load), .tx_byte(tx_byte), .spi_miso(spi_miso),
        .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
        .frame_end(frame_end)
    );

    nand_feat_dec u_dec (
        .clk(clk), .rst(rst),
        .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
        .frame_end(frame_end), .busy(busy), .rd_regs(rd_regs),
        .tx_load(tx_load), .tx_byte(tx_byte),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cmd(cmd)
    );

    nand_feat_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .busy_len(busy_len), .res_fail(res_fail), .res_ecc(res_ecc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cmd(cmd),
        .rd_regs(rd_regs), .busy(busy)
    );

endmodule

// File: tb/nand_feat_slave_bench.sv
module nand_feat_slave_bench;

    localparam int H    = 6;
    localparam int BLEN = 2000;
    localparam int WAIT = 2100;

    // {address, data written, value read back}
    localparam logic [23:0] VEC [0:10] = '{
        24'hA0FFBE, 24'hA00000, 24'hB0FFD1, 24'hB00000, 24'hD0FF60,
        24'hD02020, 24'hC0FF00, 24'hE0FF00, 24'hA01C1C, 24'h005500,
        24'hD09F00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] busy_len = 16'(BLEN);
    logic        res_fail = 1'b0;
    logic [2:0]  res_ecc = 3'b000;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nand_feat_slave u_nand_feat_slave (
        .clk(clk), .rst(rst),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .busy_len(busy_len),
        .res_fail(res_fail), .res_ecc(res_ecc)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic open_frame();
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (H + 2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (H) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic get_reg(input logic [7:0] addr, output logic [7:0] val);
        logic [7:0] d;
        open_frame();
        send_bits(8'h0F, 8, d);
        send_bits(addr, 8, d);
        send_bits(8'h00, 8, val);
        close_frame();
    endtask

    task automatic set_reg(input logic [7:0] addr, input logic [7:0] data);
        logic [7:0] d;
        open_frame();
        send_bits(8'h1F, 8, d);
        send_bits(addr, 8, d);
        send_bits(data, 8, d);
        close_frame();
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        open_frame();
        send_bits(op, 8, d);
        close_frame();
    endtask

    task automatic op_addr(input logic [7:0] op);
        logic [7:0] d;
        open_frame();
        send_bits(op, 8, d);
        send_bits(8'h00, 8, d);
        send_bits(8'h01, 8, d);
        send_bits(8'h02, 8, d);
        close_frame();
    endtask

    task automatic expect_reg(input string req, input logic [7:0] addr, input logic [7:0] exp);
        logic [7:0] v;
        get_reg(addr, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R5 reset values, R2 read path
        expect_reg("R5 lock init", 8'hA0, 8'h1C);
        expect_reg("R5 options init", 8'hB0, 8'h00);
        expect_reg("R5 R6 status init", 8'hC0, 8'h00);
        expect_reg("R5 R2 drive init", 8'hD0, 8'h00);

        // R3 R4 write/read-back table
        for (int k = 0; k <= 10; k++) begin
            set_reg(VEC[k][23:16], VEC[k][15:8]);
            expect_reg("R3 R4 table entry", VEC[k][23:16], VEC[k][7:0]);
        end

        // R7 latch set and clear
        op1(8'h06);
        expect_reg("R7 latch set", 8'hC0, 8'h02);
        op1(8'h04);
        expect_reg("R7 latch clear", 8'hC0, 8'h00);

        // R9 program without latch is ignored
        op_addr(8'h10);
        expect_reg("R9 program ignored", 8'hC0, 8'h00);

        // R8 reset busy interval
        op1(8'hFF);
        expect_reg("R8 R6 busy after reset", 8'hC0, 8'h01);
        repeat (WAIT) @(negedge clk);
        expect_reg("R8 busy ends", 8'hC0, 8'h00);

        // R12 commands ignored while busy
        op1(8'hFF);
        set_reg(8'hD0, 8'h60);
        op1(8'h06);
        repeat (WAIT) @(negedge clk);
        expect_reg("R12 write ignored busy", 8'hD0, 8'h00);
        expect_reg("R12 latch set ignored busy", 8'hC0, 8'h00);

        // R8 second reset restarts the interval
        op1(8'hFF);
        repeat (1500) @(negedge clk);
        op1(8'hFF);
        repeat (800) @(negedge clk);
        expect_reg("R8 restart keeps busy", 8'hC0, 8'h01);
        repeat (WAIT) @(negedge clk);
        expect_reg("R8 restart ends", 8'hC0, 8'h00);

        // R10 program with failure
        res_fail = 1'b1;
        op1(8'h06);
        op_addr(8'h10);
        expect_reg("R10 R6 program busy with latch", 8'hC0, 8'h03);
        repeat (WAIT) @(negedge clk);
        expect_reg("R10 program fail, latch cleared", 8'hC0, 8'h08);

        // R10 erase pass keeps program fail
        res_fail = 1'b0;
        op1(8'h06);
        op_addr(8'hD8);
        repeat (WAIT) @(negedge clk);
        expect_reg("R10 erase pass", 8'hC0, 8'h08);

        // R10 erase fail
        res_fail = 1'b1;
        op1(8'h06);
        op_addr(8'hD8);
        repeat (WAIT) @(negedge clk);
        expect_reg("R10 erase fail", 8'hC0, 8'h0C);

        // R11 page read without latch, ECC disabled
        res_ecc = 3'b101;
        op_addr(8'h13);
        expect_reg("R11 read busy without latch", 8'hC0, 8'h0D);
        repeat (WAIT) @(negedge clk);
        expect_reg("R11 ECC gated off", 8'hC0, 8'h0C);

        // R11 ECC enabled, latch kept
        set_reg(8'hB0, 8'h10);
        op1(8'h06);
        op_addr(8'h13);
        repeat (WAIT) @(negedge clk);
        expect_reg("R11 ECC code and latch kept", 8'hC0, 8'h5E);
        expect_reg("R3 options ECC bit", 8'hB0, 8'h10);

        // R1 aborted write
        set_reg(8'hD0, 8'h40);
        expect_reg("R3 drive write", 8'hD0, 8'h40);
        open_frame();
        send_bits(8'h1F, 8, d);
        send_bits(8'hD0, 8, d);
        send_bits(8'h20, 4, d);
        close_frame();
        expect_reg("R1 aborted write no effect", 8'hD0, 8'h40);

        // R5 synchronous reset restores power-up values
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        expect_reg("R5 status after reset", 8'hC0, 8'h00);
        expect_reg("R5 lock after reset", 8'hA0, 8'h1C);
        expect_reg("R5 drive after reset", 8'hD0, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule